// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block owns the read pointer of a synchronous FIFO and lets the reader replay the stream from the beginning. When a retransmit request is seen on the read clock, the pointer is sent back to the first word stored since the last reset. For a fixed settling time the data-available flag is then forced to its "nothing to read" value and all reads are refused. After that the flag is released and reading starts again from word zero. The storage array and the write side sit outside the block. Only the number of words written since reset comes in, as `wr_count`.

Two output modes are supported, chosen by `mode_fwft`. In standard mode `stat_flag` is an active-high "not empty" indication, and each accepted read enable moves the pointer on by one. In first-word-fall-through mode an output register sits after the storage. The first available word is loaded into it without any read enable, and `stat_flag` is an active-low "output word valid" indication. The output register adds one word of capacity, so this mode allows one more word to be written before a retransmit. It also releases the flag one cycle later than standard mode. A retransmit request is refused when too many words have been written, and the refusal leaves a sticky error bit set.

Top module: `fifo_rtx_ctrl`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a clock edge) sets `rd_ptr`=0, `setup_busy`=0 and `rtx_err`=0. The output register is cleared, so with `wr_count`=0 `stat_flag` is 0 in standard mode (`mode_fwft`=0) and 1 in FWFT mode (`mode_fwft`=1).
- R2: In standard mode, outside setup, `stat_flag` is 1 exactly when `wr_count` > `rd_ptr`. A read enable sampled while `stat_flag` is 1 increments `rd_ptr` at that edge.
- R3: In FWFT mode, outside setup, the output register loads the word at `rd_ptr` at an edge without any read enable when it is empty and `wr_count` > `rd_ptr`. The load increments `rd_ptr`, and `stat_flag` is 0 while the register holds a word. A read enable while it holds a word loads the next word if one is available, or else empties the register.
- R4: A retransmit request sampled while `setup_busy`=0 is accepted when `wr_count` ≤ DEPTH−2 (standard) or ≤ DEPTH−1 (FWFT). At that edge `rd_ptr` becomes 0, the output register empties and `setup_busy` rises. The retransmit request overrides a read enable in the same cycle.
- R5: `setup_busy` stays 1 for exactly SETTLE+1 clock cycles after an accepted retransmit.
- R6: In standard mode `stat_flag` is 0 while `setup_busy` is 1. It returns to 1 in the first cycle after setup if `wr_count` > 0.
- R7: In FWFT mode `stat_flag` stays 1 during setup and for one more cycle. It falls to 0 SETTLE+2 cycles after the accepted retransmit if `wr_count` > 0.
- R8: A read enable sampled while `setup_busy` is 1 has no effect: `rd_ptr` and the output register do not change.
- R9: A retransmit request sampled while `setup_busy`=0 and `wr_count` is above the mode's limit is ignored: `rd_ptr` and normal reading carry on. It sets `rtx_err` to 1, and only reset clears it.
- R10: A retransmit request sampled while `setup_busy` is 1 is ignored. The setup window does not restart, and `rtx_err` is not set.
- R11: After setup the words are delivered again from the first word since reset. `rd_ptr` counts 0, 1, 2 as successive words are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_fwft | input | 1 | 0 = standard mode, 1 = first-word-fall-through mode; static between resets |
| rd_en | input | 1 | Read enable |
| rtx_req | input | 1 | Retransmit request |
| wr_count | input | CW | Words written since reset (write side) |
| rd_ptr | output | CW | Index of the next word to fetch from storage |
| stat_flag | output | 1 | Standard: 1 = data available; FWFT: 0 = output word valid |
| setup_busy | output | 1 | Retransmit setup in progress |
| rtx_err | output | 1 | Sticky: a retransmit was refused for overfill |

## Verification
The bench builds the block with DEPTH=8 and SETTLE=2. A shallow depth lets random writes reach both retransmit limits (6 in standard mode, 7 in FWFT mode) and pass them by one. A short settle time lets many retransmits complete in one run, which exercises the release edges, reads during setup and requests during setup over and over. Each mode gets directed sequences that hit the exact release cycles and the limit boundaries. Random traffic with occasional resets follows, compared cycle by cycle against a behavioural model.

// File: rtl/fifo_rtx_pkg.sv
// Package: shared types and helpers for the FIFO retransmit controller.
// Assumes: DEPTH is the storage depth in words, not counting the FWFT output register.
package fifo_rtx_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Highest write count at which a retransmit may still be accepted.
    function automatic int unsigned rtx_limit(input int unsigned depth, input fifo_mode_e mode);
        return (mode == MODE_FWFT) ? depth - 1 : depth - 2;
    endfunction

endpackage

// File: rtl/rtx_settle_timer.sv
// Module: counts the retransmit settling window and flags it as busy.
// Assumes: start is pulsed only while busy is low; the window lasts SETTLE+1 cycles.
module rtx_settle_timer #(
    parameter int unsigned SETTLE = 3,
    localparam int unsigned CNT_W = $clog2(SETTLE + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE + 1);

    logic [CNT_W-1:0] cnt;

    // Load the window on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Busy while any settling cycles remain.
    always_comb busy = (cnt != '0);

    AST_START_LOADS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == LOAD)); // R5

    AST_WINDOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5

endmodule

// File: rtl/rtx_rd_pointer.sv
// Module: read pointer and FWFT output-register occupancy.
// Assumes: wr_count rises monotonically between resets; hold masks all reads;
// rewind has priority over every other update.
module rtx_rd_pointer #(
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwft,
    input  logic             rewind,
    input  logic             hold,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wr_count,
    output logic [PTR_W-1:0] ptr,
    output logic             out_valid,
    output logic             avail
);

    logic std_adv;
    logic fwft_load;
    logic fwft_drop;

    // Decide which pointer or output-register update this cycle makes.
    always_comb begin
        avail     = (wr_count > ptr);
        std_adv   = !fwft && !hold && rd_en && avail;
        fwft_load = fwft && !hold && avail && (!out_valid || rd_en);
        fwft_drop = fwft && !hold && out_valid && rd_en && !avail;
    end

    // Pointer and output-register state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            out_valid <= 1'b0;
        end else if (rewind) begin
            ptr       <= '0;
            out_valid <= 1'b0;
        end else begin
            if (std_adv || fwft_load) begin
                ptr <= ptr + PTR_W'(1);
            end
            if (fwft_load) begin
                out_valid <= 1'b1;
            end else if (fwft_drop) begin
                out_valid <= 1'b0;
            end
        end
    end

    AST_REWIND_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (ptr == '0 && !out_valid)); // R4

    AST_FROZEN_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !rewind) |=> ($stable(ptr) && $stable(out_valid))); // R8

    AST_PTR_NOT_PAST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= wr_count); // R2

    AST_STD_NO_OUTREG: assert property (@(posedge clk) disable iff (!rst_n)
        !fwft |=> !out_valid); // R2

endmodule

// File: rtl/fifo_rtx_ctrl.sv
// Module: top of the read-side retransmit controller.
// Accepts or refuses retransmit requests, drives the mode-dependent status flag
// and keeps the sticky refusal error.
// Assumes: mode_fwft is static between resets; wr_count comes from the write side
// and counts words written since the last reset.
module fifo_rtx_ctrl #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned SETTLE = 3,
    localparam int unsigned CW    = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_fwft,
    input  logic          rd_en,
    input  logic          rtx_req,
    input  logic [CW-1:0] wr_count,
    output logic [CW-1:0] rd_ptr,
    output logic          stat_flag,
    output logic          setup_busy,
    output logic          rtx_err
);

    import fifo_rtx_pkg::*;

    localparam logic [CW-1:0] LIM_STD  = CW'(rtx_limit(DEPTH, MODE_STD));
    localparam logic [CW-1:0] LIM_FWFT = CW'(rtx_limit(DEPTH, MODE_FWFT));

    fifo_mode_e    mode;
    logic [CW-1:0] limit;
    logic          rtx_ok;
    logic          rtx_bad;
    logic          busy;
    logic          out_valid;
    logic          avail;

    // Decode mode, limit and retransmit acceptance.
    always_comb begin
        mode    = fifo_mode_e'(mode_fwft);
        limit   = (mode == MODE_FWFT) ? LIM_FWFT : LIM_STD;
        rtx_ok  = rtx_req && !busy && (wr_count <= limit);
        rtx_bad = rtx_req && !busy && (wr_count > limit);
    end

    rtx_settle_timer #(
        .SETTLE(SETTLE)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(rtx_ok),
        .busy (busy)
    );

    rtx_rd_pointer #(
        .PTR_W(CW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwft     (mode == MODE_FWFT),
        .rewind   (rtx_ok),
        .hold     (busy),
        .rd_en    (rd_en),
        .wr_count (wr_count),
        .ptr      (rd_ptr),
        .out_valid(out_valid),
        .avail    (avail)
    );

    // Sticky error for refused retransmits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtx_err <= 1'b0;
        end else if (rtx_bad) begin
            rtx_err <= 1'b1;
        end
    end

    // Mode-dependent status flag and busy output.
    always_comb begin
        setup_busy = busy;
        if (mode == MODE_FWFT) begin
            stat_flag = !out_valid;
        end else begin
            stat_flag = !busy && avail;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rtx_err |=> rtx_err); // R9

    AST_FWFT_EMPTY_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid); // R7

    AST_BUSY_REQ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rtx_err) |=> !rtx_err); // R10

    AST_ACCEPT_STARTS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        rtx_ok |=> (busy && rd_ptr == '0)); // R4

endmodule

// File: tb/tb_fifo_rtx_ctrl.sv
module tb_fifo_rtx_ctrl;

    localparam int unsigned DEPTH  = 8;
    localparam int unsigned SETTLE = 2;
    localparam int unsigned CW     = $clog2(DEPTH + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_fwft = 1'b0;
    logic          rd_en = 1'b0;
    logic          rtx_req = 1'b0;
    logic [CW-1:0] wr_count = '0;
    logic [CW-1:0] rd_ptr;
    logic          stat_flag;
    logic          setup_busy;
    logic          rtx_err;

    int vecs = 0;
    int fails = 0;

    // Reference model state
    int m_ptr = 0;
    int m_cnt = 0;
    bit m_ov  = 1'b0;
    bit m_err = 1'b0;

    always #2.5 clk = ~clk;

    fifo_rtx_ctrl #(.DEPTH(DEPTH), .SETTLE(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .mode_fwft(mode_fwft), .rd_en(rd_en),
        .rtx_req(rtx_req), .wr_count(wr_count), .rd_ptr(rd_ptr),
        .stat_flag(stat_flag), .setup_busy(setup_busy), .rtx_err(rtx_err)
    );

    function automatic int lim_of(bit fw);
        return fw ? DEPTH - 1 : DEPTH - 2;
    endfunction

    function automatic bit exp_flag();
        if (mode_fwft) return !m_ov;
        return (m_cnt == 0) && (int'(wr_count) > m_ptr);
    endfunction

    // Behavioural model built from the requirements.
    always @(posedge clk) begin
        bit busy_now;
        bit av;
        busy_now = (m_cnt != 0);
        av = int'(wr_count) > m_ptr;
        if (!rst_n) begin
            m_ptr <= 0; m_cnt <= 0; m_ov <= 0; m_err <= 0;
        end else if (rtx_req && !busy_now && int'(wr_count) <= lim_of(mode_fwft)) begin
            m_ptr <= 0; m_ov <= 0; m_cnt <= SETTLE + 1;
        end else begin
            if (rtx_req && !busy_now) m_err <= 1'b1;
            if (busy_now) m_cnt <= m_cnt - 1;
            if (!busy_now) begin
                if (!mode_fwft) begin
                    if (rd_en && av) m_ptr <= m_ptr + 1;
                end else if (av && (!m_ov || rd_en)) begin
                    m_ptr <= m_ptr + 1; m_ov <= 1'b1;
                end else if (m_ov && rd_en) begin
                    m_ov <= 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk(mode_fwft ? "R3 rd_ptr" : "R2 rd_ptr", int'(rd_ptr), m_ptr);
        chk(mode_fwft ? "R7 stat_flag" : "R6 stat_flag", int'(stat_flag), int'(exp_flag()));
        chk("R5 setup_busy", int'(setup_busy), int'(m_cnt != 0));
        chk("R9 rtx_err", int'(rtx_err), int'(m_err));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare_model();
    endtask

    task automatic do_reset(input bit fw);
        rst_n = 1'b0; mode_fwft = fw; rd_en = 0; rtx_req = 0; wr_count = '0;
        step();
        step();
        rst_n = 1'b1;
        chk("R1 rd_ptr", int'(rd_ptr), 0);
        chk("R1 setup_busy", int'(setup_busy), 0);
        chk("R1 rtx_err", int'(rtx_err), 0);
        chk("R1 stat_flag", int'(stat_flag), fw ? 1 : 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // ---------- Standard mode directed ----------
        do_reset(1'b0);
        wr_count = CW'(3);
        rd_en = 1;
        step(); step();
        chk("R2 two reads", int'(rd_ptr), 2);
        rtx_req = 1;               // with rd_en still high: retransmit wins
        step();
        rtx_req = 0;
        chk("R4 rewind ptr", int'(rd_ptr), 0);
        chk("R4 busy rises", int'(setup_busy), 1);
        chk("R6 flag low in setup", int'(stat_flag), 0);
        rtx_req = 1;               // request during setup
        step();
        rtx_req = 0;
        chk("R8 read masked", int'(rd_ptr), 0);
        chk("R10 no err in setup", int'(rtx_err), 0);
        step();
        chk("R5 busy third cycle", int'(setup_busy), 1);
        step();
        chk("R5 busy ends", int'(setup_busy), 0);
        chk("R10 window not restarted", int'(setup_busy), 0);
        chk("R6 flag released", int'(stat_flag), 1);
        chk("R8 ptr still 0", int'(rd_ptr), 0);
        step();
        chk("R11 first word", int'(rd_ptr), 1);
        step();
        chk("R11 second word", int'(rd_ptr), 2);
        rd_en = 0;
        wr_count = CW'(DEPTH - 2);  // boundary: accepted
        rtx_req = 1;
        step();
        rtx_req = 0;
        chk("R4 std limit accepted", int'(setup_busy), 1);
        chk("R9 no err at limit", int'(rtx_err), 0);
        repeat (SETTLE + 1) step();
        rd_en = 1;
        step();
        rd_en = 0;
        wr_count = CW'(DEPTH - 1);  // one over: refused
        rtx_req = 1;
        step();
        rtx_req = 0;
        chk("R9 err set", int'(rtx_err), 1);
        chk("R9 ptr kept", int'(rd_ptr), 1);
        chk("R9 no setup", int'(setup_busy), 0);
        step();
        chk("R9 err sticky", int'(rtx_err), 1);

        // ---------- FWFT mode directed ----------
        do_reset(1'b1);
        wr_count = CW'(2);
        step();
        chk("R3 auto load ptr", int'(rd_ptr), 1);
        chk("R3 ready low", int'(stat_flag), 0);
        rd_en = 1;
        step();
        chk("R3 second word", int'(rd_ptr), 2);
        step();
        rd_en = 0;
        chk("R3 register empties", int'(stat_flag), 1);
        wr_count = CW'(DEPTH - 1);  // FWFT boundary: accepted
        rtx_req = 1;
        step();
        rtx_req = 0;
        chk("R4 fwft limit accepted", int'(setup_busy), 1);
        chk("R7 not ready", int'(stat_flag), 1);
        step(); step();
        step();
        chk("R5 fwft busy ends", int'(setup_busy), 0);
        chk("R7 extra cycle high", int'(stat_flag), 1);
        step();
        chk("R7 ready low", int'(stat_flag), 0);
        chk("R11 fwft first word", int'(rd_ptr), 1);
        rd_en = 1;
        step();
        rd_en = 0;
        chk("R11 fwft second word", int'(rd_ptr), 2);
        wr_count = CW'(DEPTH);      // one over FWFT limit
        rtx_req = 1;
        step();
        rtx_req = 0;
        chk("R9 fwft err", int'(rtx_err), 1);

        // ---------- Random traffic, both modes ----------
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            for (int i = 0; i < 3000; i++) begin
                int cap;
                cap = md ? DEPTH + 1 : DEPTH;
                if ($urandom_range(499, 0) == 0) begin
                    rst_n = 0; wr_count = '0;
                end else begin
                    rst_n = 1;
                    if (int'(wr_count) < cap && $urandom_range(2, 0) == 0)
                        wr_count = wr_count + CW'(1);
                end
                rd_en   = ($urandom_range(1, 0) == 0);
                rtx_req = ($urandom_range(15, 0) == 0);
                step();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule